// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with HI/LO Result Words

This block multiplies two `WIDTH`-bit operands over `WIDTH` clock cycles and leaves the `2*WIDTH`-bit product split into an upper word (`hi`) and a lower word (`lo`). A single request is accepted with a one-cycle `start` pulse. At that pulse the block also samples `is_signed`, which selects whether the operands are read as two's-complement or as unsigned values. The core loop uses one working register twice the operand width. The multiplier operand is loaded into its lower half and the upper half is cleared. In each cycle the multiplicand is conditionally added to the upper half, depending on the register's least significant bit, and the whole register shifts right by one in the same cycle. The carry-out of that add enters the vacated top bit.

Signed requests are computed on operand magnitudes. The final product is negated when the operand signs differ. On completion the block raises `done` for one cycle and loads `hi`, `lo` and an overflow flag. The flag reports whether the product needs more than `WIDTH` bits. All three stay unchanged until the next request completes.

Top module: `mulseq_hilo`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `hi`, `lo` and `ovf` are all 0.
- R2: For an unsigned request, `{hi, lo}` equals the full `2*WIDTH`-bit product of the operands. `hi` holds bits `2*WIDTH-1` down to `WIDTH` and `lo` holds bits `WIDTH-1` down to 0.
- R3: For a signed request (`is_signed` = 1), `{hi, lo}` is the two's-complement product of the operands. This includes operands equal to the most negative value.
- R4: `done` is high for exactly one cycle. That cycle comes `WIDTH` clock cycles after the edge on which `start` was accepted.
- R5: `start` is accepted only when `busy` is low. `busy` is high from the cycle after acceptance up to the `done` cycle, where it is low. A `start` raised while `busy` is high has no effect on the result or on the timing.
- R6: `hi`, `lo` and `ovf` change only in the cycle where `done` is high, and otherwise hold their last values.
- R7: For an unsigned request, `ovf` is 1 exactly when `hi` is nonzero.
- R8: For a signed request, `ovf` is 1 exactly when `hi` differs from `WIDTH` copies of `lo[WIDTH-1]`.
- R9: No partial-sum carry is lost. The all-ones times all-ones unsigned product comes out with `hi` = all-ones minus one and `lo` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled when idle |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| opnd_a | input | WIDTH | Multiplicand |
| opnd_b | input | WIDTH | Multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | WIDTH | Upper word of the product |
| lo | output | WIDTH | Lower word of the product |
| ovf | output | 1 | Product does not fit in `WIDTH` bits |

## Verification
A wrong iteration count or a carry dropped from the shift register shows up directly in `hi`/`lo`, in the `done` cycle of the same request. Low-order bit errors land in `lo` and a lost carry lands in `hi`. A flaw in the sign handling only appears for requests with mixed signs or with the most negative operand. For that reason every operand pair of a 4-bit instance is swept in both modes. Control faults show up as `done` arriving off the `WIDTH`-cycle mark, or as a result word that moves outside its `done` cycle.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } mul_phase_e;
endpackage

// File: rtl/mulseq_operand_prep.sv
module mulseq_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic             is_signed,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] mag_a,
   output logic [WIDTH-1:0] mag_b,
   output logic             flip
);
   localparam int MSB = WIDTH - 1;

   logic neg_a, neg_b;

   always_comb begin
      neg_a = is_signed & opnd_a[MSB];
      neg_b = is_signed & opnd_b[MSB];
      // magnitude of the most negative value is still representable unsigned
      mag_a = neg_a ? (~opnd_a + 1'b1) : opnd_a;
      mag_b = neg_b ? (~opnd_b + 1'b1) : opnd_b;
      flip  = neg_a ^ neg_b;
   end
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
   import mulseq_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic last,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(WIDTH) + 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

   mul_phase_e    phase_q;
   logic [CW-1:0] cnt_q;

   always_comb begin
      load = (phase_q == PH_IDLE) && start;
      step = (phase_q == PH_RUN);
      last = step && (cnt_q == LAST_CNT);
      busy = (phase_q == PH_RUN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= last;
         if (load) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
         end else if (last) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mulseq_accum.sv
module mulseq_accum #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             last,
   input  logic             is_signed,
   input  logic             flip,
   input  logic [WIDTH-1:0] mag_a,
   input  logic [WIDTH-1:0] mag_b,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo,
   output logic             ovf
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    work_q;
   logic             flip_q;
   logic             sgn_q;
   logic [WIDTH:0]   psum;
   logic [PW-1:0]    work_nxt;
   logic [PW-1:0]    final_p;
   logic [WIDTH-1:0] fin_hi, fin_lo;
   logic             fin_ovf;

   always_comb begin
      psum     = {1'b0, work_q[PW-1:WIDTH]}
               + {1'b0, (work_q[0] ? mcand_q : {WIDTH{1'b0}})};
      // add and shift in one step: carry-out becomes the new top bit
      work_nxt = {psum, work_q[WIDTH-1:1]};
      final_p  = flip_q ? (~work_nxt + 1'b1) : work_nxt;
      fin_hi   = final_p[PW-1:WIDTH];
      fin_lo   = final_p[WIDTH-1:0];
      fin_ovf  = sgn_q ? (fin_hi != {WIDTH{fin_lo[WIDTH-1]}})
                       : (fin_hi != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         work_q  <= '0;
         flip_q  <= 1'b0;
         sgn_q   <= 1'b0;
         hi      <= '0;
         lo      <= '0;
         ovf     <= 1'b0;
      end else begin
         if (load) begin
            mcand_q <= mag_a;
            work_q  <= {{WIDTH{1'b0}}, mag_b};
            flip_q  <= flip;
            sgn_q   <= is_signed;
         end else if (step) begin
            work_q <= work_nxt;
         end
         if (last) begin
            hi  <= fin_hi;
            lo  <= fin_lo;
            ovf <= fin_ovf;
         end
      end
   end
endmodule

// File: rtl/mulseq_hilo.sv
module mulseq_hilo #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo,
   output logic             ovf
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("mulseq_hilo: WIDTH must be at least 2");
      end
   endgenerate

   logic             load, step, last, flip;
   logic [WIDTH-1:0] mag_a, mag_b;

   mulseq_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .is_signed(is_signed),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .mag_a    (mag_a),
      .mag_b    (mag_b),
      .flip     (flip)
   );

   mulseq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .load (load),
      .step (step),
      .last (last),
      .busy (busy),
      .done (done)
   );

   mulseq_accum #(.WIDTH(WIDTH)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .last     (last),
      .is_signed(is_signed),
      .flip     (flip),
      .mag_a    (mag_a),
      .mag_b    (mag_b),
      .hi       (hi),
      .lo       (lo),
      .ovf      (ovf)
   );
endmodule

// File: rtl/mulseq_hilo_chk.sv
module mulseq_hilo_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] hi,
   input logic [WIDTH-1:0] lo,
   input logic             ovf
);
   localparam int CW = $clog2(WIDTH) + 2;

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_cnt <= '0;
      else if (start && !busy) run_cnt <= '0;
      else if (busy)           run_cnt <= run_cnt + 1'b1;
   end

   // R1: outputs clear while reset is held
   always @(posedge clk) begin
      if (!rst_n)
         assert_reset_clear_R1: assert (!busy && !done && hi == '0 && lo == '0 && !ovf);
   end

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == CW'(WIDTH)));

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_busy_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(hi) && $stable(lo) && $stable(ovf)));
endmodule

bind mulseq_hilo mulseq_hilo_chk #(.WIDTH(WIDTH)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .busy (busy),
   .done (done),
   .hi   (hi),
   .lo   (lo),
   .ovf  (ovf)
);

// File: tb/sim_mulseq_hilo.sv
module sim_mulseq_hilo;
   localparam int SW = 4;
   localparam int LW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic          s_start = 1'b0, s_sgn = 1'b0;
   logic [SW-1:0] s_a = '0, s_b = '0;
   logic          s_busy, s_done, s_ovf;
   logic [SW-1:0] s_hi, s_lo;

   logic          l_start = 1'b0, l_sgn = 1'b0;
   logic [LW-1:0] l_a = '0, l_b = '0;
   logic          l_busy, l_done, l_ovf;
   logic [LW-1:0] l_hi, l_lo;

   mulseq_hilo #(.WIDTH(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(s_start), .is_signed(s_sgn),
      .opnd_a(s_a), .opnd_b(s_b), .busy(s_busy), .done(s_done),
      .hi(s_hi), .lo(s_lo), .ovf(s_ovf));

   mulseq_hilo #(.WIDTH(LW)) u1 (
      .clk(clk), .rst_n(rst_n), .start(l_start), .is_signed(l_sgn),
      .opnd_a(l_a), .opnd_b(l_b), .busy(l_busy), .done(l_done),
      .hi(l_hi), .lo(l_lo), .ovf(l_ovf));

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected product and overflow from the requirement definitions
   task automatic expect_mul(input int w, input logic [63:0] a, input logic [63:0] b,
                             input bit sgn, output logic [63:0] ehi,
                             output logic [63:0] elo, output logic eovf);
      logic [63:0] mask, ea, eb, p, ext;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
      ea = a & mask;
      eb = b & mask;
      if (sgn) begin
         ea = 64'($signed(ea << (64 - w)) >>> (64 - w));
         eb = 64'($signed(eb << (64 - w)) >>> (64 - w));
      end
      p   = ea * eb;
      elo = p & mask;
      ehi = (p >> w) & mask;
      if (sgn) begin
         ext  = ((elo >> (w - 1)) & 64'd1) != 0 ? mask : 64'd0;
         eovf = (ehi != ext);
      end else begin
         eovf = (ehi != 0);
      end
   endtask

   task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b, input bit sgn);
      logic [63:0] ehi, elo;
      logic eovf;
      int lat;
      @(negedge clk);
      s_a = a; s_b = b; s_sgn = sgn; s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      lat = 1;
      while (!s_done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      expect_mul(SW, 64'(a), 64'(b), sgn, ehi, elo, eovf);
      chk(sgn ? "R3 product" : "R2 product", 128'({s_hi, s_lo}), 128'({ehi[SW-1:0], elo[SW-1:0]}));
      chk(sgn ? "R8 ovf" : "R7 ovf", 128'(s_ovf), 128'(eovf));
      chk("R4 latency", 128'(lat - 1), 128'(SW));
   endtask

   task automatic run_large(input logic [LW-1:0] a, input logic [LW-1:0] b, input bit sgn,
                            input bit poke_busy, input string tag);
      logic [63:0] ehi, elo;
      logic eovf;
      int lat;
      @(negedge clk);
      l_a = a; l_b = b; l_sgn = sgn; l_start = 1'b1;
      @(negedge clk);
      l_start = 1'b0;
      chk("R5 busy after accept", 128'(l_busy), 128'(1));
      lat = 1;
      while (!l_done && lat < 200) begin
         if (poke_busy && lat == 5) begin
            l_a = 32'h1234_5678; l_b = 32'h0000_0003; l_sgn = ~sgn; l_start = 1'b1;
         end else begin
            l_start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      l_start = 1'b0;
      expect_mul(LW, 64'(a), 64'(b), sgn, ehi, elo, eovf);
      chk({tag, " hi"}, 128'(l_hi), 128'(ehi[LW-1:0]));
      chk({tag, " lo"}, 128'(l_lo), 128'(elo[LW-1:0]));
      chk(sgn ? "R8 ovf" : "R7 ovf", 128'(l_ovf), 128'(eovf));
      chk("R4 latency", 128'(lat - 1), 128'(LW));
      chk("R5 busy low at done", 128'(l_busy), 128'(0));
      @(negedge clk);
      chk("R4 done one cycle", 128'(l_done), 128'(0));
      repeat (3) @(negedge clk);
      chk("R6 hold", 128'({l_hi, l_lo, l_ovf}), 128'({ehi[LW-1:0], elo[LW-1:0], eovf}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset small", 128'({s_busy, s_done, s_hi, s_lo, s_ovf}), 128'(0));
      chk("R1 reset large", 128'({l_busy, l_done, l_hi, l_lo, l_ovf}), 128'(0));
      rst_n = 1'b1;

      for (int m = 0; m < 2; m++)
         for (int i = 0; i < (1 << SW); i++)
            for (int j = 0; j < (1 << SW); j++)
               run_small(SW'(i), SW'(j), bit'(m));

      run_large(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 carry");
      run_large(32'd123456789, 32'd987654, 1'b0, 1'b0, "R2 unsigned");
      run_large(32'd70000, 32'd3, 1'b0, 1'b0, "R2 no-ovf");
      run_large(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R3 neg*neg");
      run_large(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R3 minneg sq");
      run_large(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, "R3 minneg*1");
      run_large(32'h7FFF_FFFF, 32'hFFFF_FFFD, 1'b1, 1'b0, "R3 mixed");
      run_large(32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 1'b0, "R2 zero");
      run_large(32'h0001_0003, 32'hFFFE_0005, 1'b1, 1'b1, "R5 start ignored");
      run_large(32'hCAFE_0001, 32'h0BAD_F00D, 1'b0, 1'b1, "R5 start ignored");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc >= 150000);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule